// File: doc/BRIEF.md
# Prefetch Duplicate Filter

This block sits on the path from a sequential prefetch engine to the second-level cache. It remembers the block addresses of the last few prefetches it let through. Any new prefetch request whose block address matches one of those remembered addresses is dropped. When a sequential engine issues overlapping bursts, so that one burst repeats most of the blocks of the burst before it, only the blocks not yet requested reach the cache. This saves cache lookups.

Requests arrive with a valid/ready handshake. A request that misses in the buffer is placed in a one-entry output register that has its own valid/ready handshake toward the cache. The same request is also written into the buffer. A request that hits is accepted on the input side and produces nothing on the output side. Replacement in the buffer is first-in first-out. A flush input clears the whole buffer. Two wrapping counters report how many requests were forwarded and how many were filtered.

Top module: `pf_dup_filter`

## Requirements
- R1: After reset, out_valid is 0, both counters are 0 and the buffer is empty, so the first accepted request is always forwarded.
- R2: req_ready is 1 exactly when flush is 0 and the output register is free, meaning out_valid is 0 or out_ready is 1. A request is accepted on a rising edge where req_valid and req_ready are both 1.
- R3: When an accepted request matches no valid buffer entry, out_valid is 1 and out_addr equals the request address after that edge. The two stay unchanged while out_ready is 0, and out_valid clears after an edge with out_ready at 1 and no new forward.
- R4: When an accepted request matches a valid entry, it is dropped. The output register is not loaded, and drop_count increases by one.
- R5: A forwarded address is in the buffer from the very next cycle, so the same address accepted in the following cycle is dropped.
- R6: The buffer holds DEPTH entries (4 by default) and replaces first-in first-out. After DEPTH+1 distinct forwarded addresses, the first of them is forwarded again and the second is still dropped.
- R7: A cycle with flush at 1 invalidates every entry and accepts no request. Any address accepted afterwards is forwarded.
- R8: fwd_count and drop_count count forwarded and dropped accepted requests, modulo 2^CNT_W. A cycle with no acceptance leaves both unchanged.
- R9: With burst blocks b+1..b+4 followed by b+2..b+5, only b+5 is forwarded from the second burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all buffer entries |
| req_valid | input | 1 | Prefetch request present |
| req_ready | output | 1 | Filter can accept a request |
| req_addr | input | ADDR_W | Block address of the request |
| out_valid | output | 1 | Forwarded request present toward the cache |
| out_ready | input | 1 | Cache takes the forwarded request |
| out_addr | output | ADDR_W | Forwarded block address |
| fwd_count | output | CNT_W | Number of forwarded requests |
| drop_count | output | CNT_W | Number of filtered requests |

## Verification
The hardest case to reach from the ports is an eviction while the output is backpressured and requests keep arriving. In that case the oldest entry must leave the buffer at the same time as a new entry enters. Random stimulus keeps addresses in a window of about three times the buffer depth and holds out_ready low often, so evictions, re-forwards and stalls overlap. Directed sequences cover the exact first-in first-out order, back-to-back duplicates, flush, and the overlapping-burst pattern.

// File: rtl/pfdf_pkg.sv
package pfdf_pkg;
  typedef enum logic [1:0] {
    DEC_IDLE = 2'd0,
    DEC_FWD  = 2'd1,
    DEC_DROP = 2'd2
  } pfdf_dec_e;
endpackage

// File: rtl/pfdf_entry_store.sv
module pfdf_entry_store #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ins_en,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [ADDR_W-1:0] tag_q [DEPTH];
  logic [DEPTH-1:0]  vld_q, vld_d, match;
  logic [PW-1:0]     wp_q, wp_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign match[g] = vld_q[g] && (tag_q[g] == look_addr);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[g] <= '0;
      end else if (ins_en && (wp_q == PW'(g))) begin
        tag_q[g] <= ins_addr;
      end
    end
  end

  assign hit = |match;

  always_comb begin
    vld_d = vld_q;
    wp_d  = wp_q;
    if (clr) begin
      vld_d = '0;
      wp_d  = '0;
    end else if (ins_en) begin
      vld_d[wp_q] = 1'b1;
      wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      wp_q  <= '0;
    end else begin
      vld_q <= vld_d;
      wp_q  <= wp_d;
    end
  end
endmodule

// File: rtl/pfdf_out_reg.sv
module pfdf_out_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              take,
  output logic              vld,
  output logic [ADDR_W-1:0] addr
);
  logic              vld_d;
  logic              addr_en;

  always_comb begin
    vld_d   = vld;
    addr_en = 1'b0;
    if (load) begin
      vld_d   = 1'b1;
      addr_en = 1'b1;
    end else if (take) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
    end else begin
      vld <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (addr_en) begin
      addr <= load_addr;
    end
  end
endmodule

// File: rtl/pfdf_counters.sv
module pfdf_counters
  import pfdf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pfdf_dec_e        dec,
  output logic [CNT_W-1:0] fwd_cnt,
  output logic [CNT_W-1:0] drop_cnt
);
  logic fwd_en, drop_en;

  assign fwd_en  = (dec == DEC_FWD);
  assign drop_en = (dec == DEC_DROP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_cnt <= '0;
    end else if (fwd_en) begin
      fwd_cnt <= fwd_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_cnt <= '0;
    end else if (drop_en) begin
      drop_cnt <= drop_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pf_dup_filter.sv
module pf_dup_filter
  import pfdf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [CNT_W-1:0]  fwd_count,
  output logic [CNT_W-1:0]  drop_count
);
  logic      hit, accept;
  pfdf_dec_e dec;

  assign req_ready = !flush && (!out_valid || out_ready);
  assign accept    = req_valid && req_ready;

  always_comb begin
    dec = DEC_IDLE;
    if (accept) dec = hit ? DEC_DROP : DEC_FWD;
  end

  pfdf_entry_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (flush),
    .ins_en    (dec == DEC_FWD),
    .ins_addr  (req_addr),
    .look_addr (req_addr),
    .hit       (hit)
  );

  pfdf_out_reg #(.ADDR_W(ADDR_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (dec == DEC_FWD),
    .load_addr (req_addr),
    .take      (out_ready),
    .vld       (out_valid),
    .addr      (out_addr)
  );

  pfdf_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec      (dec),
    .fwd_cnt  (fwd_count),
    .drop_cnt (drop_count)
  );
endmodule

// File: rtl/pf_dup_filter_chk.sv
module pf_dup_filter_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [CNT_W-1:0]  fwd_count,
  input logic [CNT_W-1:0]  drop_count
);
  logic              acc;
  logic              prev_acc;
  logic [ADDR_W-1:0] prev_addr;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_acc  <= 1'b0;
      prev_addr <= '0;
    end else begin
      prev_acc  <= acc;
      prev_addr <= req_addr;
    end
  end

  a_r7_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !req_ready);

  a_r2_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !req_ready);

  a_r3_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  a_r3_fwd_loads_output: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ((fwd_count == $past(fwd_count)) ||
             (out_valid && out_addr == $past(req_addr))));

  a_r8_one_counter: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ((fwd_count != $past(fwd_count)) != (drop_count != $past(drop_count))));

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(fwd_count) && $stable(drop_count)));

  a_r5_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && prev_acc && req_addr == prev_addr) |=>
      (drop_count == $past(drop_count) + 1'b1));
endmodule

bind pf_dup_filter pf_dup_filter_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_addr   (out_addr),
  .fwd_count  (fwd_count),
  .drop_count (drop_count)
);

// File: tb/pf_dup_filter_test.sv
module pf_dup_filter_test;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int D  = 4;

  logic          clk;
  logic          rst_n;
  logic          flush;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic          out_valid;
  logic          out_ready;
  logic [AW-1:0] out_addr;
  logic [CW-1:0] fwd_count;
  logic [CW-1:0] drop_count;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] m_tag [D];
  logic          m_v   [D];
  int            m_ptr;
  logic          m_ov;
  logic [AW-1:0] m_oa;
  logic [CW-1:0] m_fc, m_dc;

  pf_dup_filter #(.ADDR_W(AW), .DEPTH(D), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .fwd_count(fwd_count), .drop_count(drop_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic model_hit(input logic [AW-1:0] a);
    for (int i = 0; i < D; i++) if (m_v[i] && m_tag[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < D; i++) begin m_v[i] = 1'b0; m_tag[i] = '0; end
    m_ptr = 0; m_ov = 1'b0; m_oa = '0; m_fc = '0; m_dc = '0;
  endtask

  // One cycle: drive at negedge, check ready, advance model at posedge, check outputs.
  task automatic step(input logic v, input logic [AW-1:0] a, input logic ordy,
                      input logic fl, input string tag);
    logic er, acc, h;
    @(negedge clk);
    req_valid = v; req_addr = a; out_ready = ordy; flush = fl;
    #2;
    er = !fl && (!m_ov || ordy);
    chk({"R2 ready ", tag}, 64'(req_ready), 64'(er));
    acc = v && er;
    h = model_hit(a);
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < D; i++) m_v[i] = 1'b0;
      m_ptr = 0;
    end
    if (acc && !h) begin
      m_tag[m_ptr] = a; m_v[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % D;
      m_ov = 1'b1; m_oa = a; m_fc = m_fc + 1'b1;
    end else begin
      if (ordy) m_ov = 1'b0;
      if (acc) m_dc = m_dc + 1'b1;
    end
    #2;
    chk({"R3 out_valid ", tag}, 64'(out_valid), 64'(m_ov));
    if (m_ov) chk({"R3 out_addr ", tag}, 64'(out_addr), 64'(m_oa));
    chk({"R8 fwd_count ", tag}, 64'(fwd_count), 64'(m_fc));
    chk({"R4 drop_count ", tag}, 64'(drop_count), 64'(m_dc));
  endtask

  logic done = 1'b0;
  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] f0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_addr = '0; out_ready = 1'b1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 fwd_count", 64'(fwd_count), 64'd0);
    chk("R1 drop_count", 64'(drop_count), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    step(1, 32'h40, 1, 0, "R1 first forwarded");
    chk("R1 first forward", 64'(fwd_count), 64'd1);

    // R5 back-to-back duplicate
    step(1, 32'h40, 1, 0, "R5 dup");
    chk("R5 dup dropped", 64'(drop_count), 64'd1);

    // R3 backpressure hold
    step(1, 32'h41, 0, 0, "R3 load");
    step(1, 32'h42, 0, 0, "R3 stall");
    chk("R3 held addr", 64'(out_addr), 64'h41);
    step(0, 32'h0, 1, 0, "R3 drain");
    chk("R3 cleared", 64'(out_valid), 64'd0);

    // R7 flush
    step(0, 32'h0, 1, 1, "R7 flush");
    f0 = fwd_count;
    step(1, 32'h40, 1, 0, "R7 after flush");
    chk("R7 refetch forwarded", 64'(fwd_count), 64'(f0 + 1'b1));

    // R6 FIFO order: A..D then E evicts A
    step(0, 32'h0, 1, 1, "R6 flush");
    for (int k = 0; k < 5; k++) step(1, 32'h100 + k, 1, 0, "R6 fill");
    f0 = fwd_count;
    step(1, 32'h102, 1, 0, "R6 keep");
    chk("R6 third still held", 64'(fwd_count), 64'(f0));
    step(1, 32'h100, 1, 0, "R6 evicted");
    chk("R6 oldest reforwarded", 64'(fwd_count), 64'(f0 + 1'b1));
    step(1, 32'h101, 1, 0, "R6 next evicted");
    chk("R6 second now evicted", 64'(fwd_count), 64'(f0 + 2));

    // R9 overlapping bursts
    step(0, 32'h0, 1, 1, "R9 flush");
    for (int k = 1; k <= 4; k++) step(1, 32'h200 + k, 1, 0, "R9 burst1");
    f0 = fwd_count;
    for (int k = 2; k <= 5; k++) step(1, 32'h200 + k, 1, 0, "R9 burst2");
    chk("R9 one new block", 64'(fwd_count), 64'(f0 + 1'b1));
    chk("R9 new block addr", 64'(out_addr), 64'h205);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 4) != 0, 32'h300 + ($urandom % 12), ($urandom % 4) != 0,
           ($urandom % 50) == 0, "rand");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule